// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block handles hardware flow control for a single UART channel. On the receive side it compares the receive FIFO fill count with three programmable levels. When automatic mode is on, it drives the active-low request-to-send pin with hysteresis, and it raises a level-style receive-threshold interrupt. On the transmit side it synchronises the active-low clear-to-send input. When automatic CTS is on, it holds back the grant that lets the transmitter begin its next character. A character that is already being shifted out is never interrupted.

The FIFO, the serializer, the baud generator and the register file sit outside the block. They connect through a fill count, a transmit request and busy pair, a one-cycle grant pulse, and a few configuration inputs. Software asserts RTS by setting `sw_rts` to 1. Automatic RTS only takes charge while that bit is 1. With automatic RTS off, the pin is a plain general-purpose output.

Top module: `uart_hw_flow`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rts_n` is 1 and both `rx_thr_irq` and `tx_go` are 0.
- R2: With `auto_rts_en` = 0, `rts_n` equals the inverse of `sw_rts` one clock later, whatever the fill count is.
- R3: With `auto_rts_en` = 1 and `sw_rts` = 0, `rts_n` is 1 one clock later and the fill count has no effect.
- R4: With `auto_rts_en` = 1 and `sw_rts` = 1, a fill count at or above `lvl_upper` makes `rts_n` 1 one clock later.
- R5: With `auto_rts_en` = 1 and `sw_rts` = 1, a fill count below `lvl_lower` makes `rts_n` 0 one clock later.
- R6: With `auto_rts_en` = 1 and `sw_rts` = 1, a count between the two levels keeps the previous throttle state. The throttle state is cleared whenever `sw_rts` = 0 or `auto_rts_en` = 0, so after arming, a count in the band gives `rts_n` = 0.
- R7: `rx_thr_irq` is 1 one clock after a cycle in which `auto_rts_en` = 1 and the count is at or above `lvl_trig`. Otherwise it is 0.
- R8: `cts_n` passes through two synchronizing flops. With `auto_cts_en` = 1, `cts_n` = 1 blocks every `tx_go` pulse, and a low `cts_n` lets a pending request be granted.
- R9: With `auto_cts_en` = 0, `cts_n` has no effect on `tx_go`.
- R10: `tx_go` is a one-cycle pulse, registered from `tx_req` = 1 and `tx_busy` = 0. It is never issued while `tx_busy` = 1, and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_rts_en | input | 1 | 1 enables automatic RTS |
| auto_cts_en | input | 1 | 1 enables automatic CTS gating |
| sw_rts | input | 1 | Software RTS bit, 1 = assert (pin low) |
| lvl_trig | input | CW | Receive interrupt trigger level |
| lvl_upper | input | CW | Level at which RTS is released |
| lvl_lower | input | CW | RTS is reasserted below this level |
| rx_count | input | CW | Receive FIFO fill count |
| rts_n | output | 1 | Active-low request-to-send pin |
| rx_thr_irq | output | 1 | Receive-threshold interrupt, level |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| tx_req | input | 1 | Transmitter has a character waiting |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_go | output | 1 | One-cycle grant to start a character |

## Verification
`rts_n` and `rx_thr_irq` are registered straight from the inputs, so each is due at the first rising edge after the stimulus. The bench drives on the falling edge and compares on the next falling edge against a model that keeps its own copy of the throttle state. A change on `cts_n` needs two synchronizer edges plus the grant register, so it reaches `tx_go` on the third edge. The CTS checks therefore wait at least four cycles after every `cts_n` change before they judge whether grants are blocked or issued.

// File: rtl/uart_hw_flow_pkg.sv
package uart_hw_flow_pkg;
  typedef enum logic [1:0] {
    RTS_GPIO   = 2'd0,
    RTS_PARKED = 2'd1,
    RTS_AUTO   = 2'd2
  } rts_mode_e;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/uart_cdc_sync.sv
module uart_cdc_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/uart_rts_ctrl.sv
module uart_rts_ctrl
  import uart_hw_flow_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_rts_en,
  input  logic          sw_rts,
  input  logic [CW-1:0] lvl_trig,
  input  logic [CW-1:0] lvl_upper,
  input  logic [CW-1:0] lvl_lower,
  input  logic [CW-1:0] rx_count,
  output logic          rts_n,
  output logic          rx_thr_irq
);
  rts_mode_e mode;
  logic      throttled_q, throttled_d;

  always_comb begin
    if (!auto_rts_en)  mode = RTS_GPIO;
    else if (!sw_rts)  mode = RTS_PARKED;
    else               mode = RTS_AUTO;
  end

  always_comb begin
    throttled_d = 1'b0;
    if (mode == RTS_AUTO) begin
      if (rx_count >= lvl_upper)     throttled_d = 1'b1;
      else if (rx_count < lvl_lower) throttled_d = 1'b0;
      else                           throttled_d = throttled_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      throttled_q <= 1'b0;
      rts_n       <= 1'b1;
      rx_thr_irq  <= 1'b0;
    end else begin
      throttled_q <= throttled_d;
      case (mode)
        RTS_GPIO:   rts_n <= ~sw_rts;
        RTS_PARKED: rts_n <= 1'b1;
        default:    rts_n <= throttled_d;
      endcase
      rx_thr_irq <= auto_rts_en && (rx_count >= lvl_trig);
    end
  end
endmodule

// File: rtl/uart_cts_gate.sv
module uart_cts_gate (
  input  logic clk,
  input  logic rst,
  input  logic auto_cts_en,
  input  logic cts_n_sync,
  input  logic tx_req,
  input  logic tx_busy,
  output logic tx_go
);
  logic clear_ok;

  assign clear_ok = !auto_cts_en || !cts_n_sync;

  always_ff @(posedge clk) begin
    if (rst) tx_go <= 1'b0;
    else     tx_go <= tx_req && !tx_busy && !tx_go && clear_ok;
  end
endmodule

// File: rtl/uart_hw_flow.sv
module uart_hw_flow
  import uart_hw_flow_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int SYNC_STAGES = 2,
  localparam int CW = cnt_width(FIFO_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic          sw_rts,
  input  logic [CW-1:0] lvl_trig,
  input  logic [CW-1:0] lvl_upper,
  input  logic [CW-1:0] lvl_lower,
  input  logic [CW-1:0] rx_count,
  output logic          rts_n,
  output logic          rx_thr_irq,
  input  logic          cts_n,
  input  logic          tx_req,
  input  logic          tx_busy,
  output logic          tx_go
);
  logic cts_n_sync;

  uart_rts_ctrl #(.CW(CW)) u_rts (
    .clk(clk), .rst(rst), .auto_rts_en(auto_rts_en), .sw_rts(sw_rts),
    .lvl_trig(lvl_trig), .lvl_upper(lvl_upper), .lvl_lower(lvl_lower),
    .rx_count(rx_count), .rts_n(rts_n), .rx_thr_irq(rx_thr_irq)
  );

  uart_cdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk(clk), .rst(rst), .d_async(cts_n), .q_sync(cts_n_sync)
  );

  uart_cts_gate u_gate (
    .clk(clk), .rst(rst), .auto_cts_en(auto_cts_en), .cts_n_sync(cts_n_sync),
    .tx_req(tx_req), .tx_busy(tx_busy), .tx_go(tx_go)
  );
endmodule

// File: rtl/uart_hw_flow_chk.sv
module uart_hw_flow_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          auto_rts_en,
  input logic          auto_cts_en,
  input logic          sw_rts,
  input logic [CW-1:0] lvl_trig,
  input logic [CW-1:0] lvl_upper,
  input logic [CW-1:0] lvl_lower,
  input logic [CW-1:0] rx_count,
  input logic          rts_n,
  input logic          rx_thr_irq,
  input logic          cts_n,
  input logic          tx_req,
  input logic          tx_busy,
  input logic          tx_go
);
  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> rts_n && !rx_thr_irq && !tx_go); // R1
  AST_GPIO_MIRROR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(auto_rts_en) |-> rts_n == !$past(sw_rts)); // R2
  AST_PARKED_HIGH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(auto_rts_en) && !$past(sw_rts) |-> rts_n); // R3
  AST_RELEASE_UPPER: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(auto_rts_en && sw_rts && rx_count >= lvl_upper) |-> rts_n); // R4
  AST_ASSERT_LOWER: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(auto_rts_en && sw_rts && rx_count < lvl_lower && rx_count < lvl_upper) |-> !rts_n); // R5
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rx_thr_irq == $past(auto_rts_en && rx_count >= lvl_trig)); // R7
  AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    $past(auto_cts_en) && $past(cts_n, 2) && $past(cts_n, 3) |-> !tx_go); // R8
  AST_GO_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    tx_go |-> $past(tx_req) && !$past(tx_busy)); // R10
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_go |=> !tx_go); // R10
endmodule

bind uart_hw_flow uart_hw_flow_chk #(.CW(CW)) u_chk (.*);

// File: tb/uart_hw_flow_bench.sv
module uart_hw_flow_bench;
  localparam int DEPTH = 128;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic auto_rts_en = 0, auto_cts_en = 0, sw_rts = 0;
  logic [CW-1:0] lvl_trig = 0, lvl_upper = 0, lvl_lower = 0, rx_count = 0;
  logic cts_n = 1, tx_req = 0, tx_busy = 0;
  logic rts_n, rx_thr_irq, tx_go;

  int n_chk = 0, n_fail = 0;
  bit model_thr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_hw_flow #(.FIFO_DEPTH(DEPTH)) u_uart_hw_flow (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit next_thr(input bit a, input bit s, input int c, input int up, input int lo, input bit prev);
    if (!a || !s) return 0;
    if (c >= up) return 1;
    if (c < lo) return 0;
    return prev;
  endfunction

  function automatic bit exp_rts(input bit a, input bit s, input bit thr);
    if (!a) return !s;
    if (!s) return 1;
    return thr;
  endfunction

  task automatic rts_step(input string req);
    bit nt;
    nt = next_thr(auto_rts_en, sw_rts, rx_count, lvl_upper, lvl_lower, model_thr);
    step();
    model_thr = nt;
    check(req, rts_n, exp_rts(auto_rts_en, sw_rts, nt));
  endtask

  task automatic count_go(input int cycles, output int gos);
    gos = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (tx_go) begin
        gos++;
        check("R10 busy", tx_busy, 0);
      end
    end
  endtask

  initial begin
    int gos;
    int lo, tr, up;
    @(negedge clk);
    check("R1 rts_n", rts_n, 1);
    check("R1 irq", rx_thr_irq, 0);
    check("R1 go", tx_go, 0);
    rst = 0;
    step();
    check("R1 rts_n after", rts_n, 1);

    // R2 GPIO mode ignores counts
    rx_count = 120; lvl_upper = 10; sw_rts = 1;
    rts_step("R2 gpio on");
    sw_rts = 0; rts_step("R2 gpio off");

    // R3 parked: auto on, sw off, count below lower
    auto_rts_en = 1; lvl_lower = 20; lvl_trig = 40; lvl_upper = 60; rx_count = 0;
    rts_step("R3 parked");
    // R6 arm in band gives asserted
    rx_count = 50; sw_rts = 1;
    rts_step("R6 arm in band");
    rx_count = 60; rts_step("R4 at upper");
    check("R7 irq high", rx_thr_irq, 1);
    rx_count = 30; rts_step("R6 hold high");
    check("R7 irq low", rx_thr_irq, 0);
    rx_count = 40; rts_step("R6 hold at trig");
    check("R7 irq at trig", rx_thr_irq, 1);
    rx_count = 20; rts_step("R6 hold at lower");
    rx_count = 19; rts_step("R5 below lower");
    rx_count = 59; rts_step("R6 hold low");
    auto_rts_en = 0; rx_count = 100; rts_step("R2 back to gpio");
    check("R7 irq off in gpio", rx_thr_irq, 0);
    auto_rts_en = 1;

    // R2..R7 random walk
    void'($urandom(32'h5eed1234));
    for (int seg = 0; seg < 20; seg++) begin
      lo = $urandom_range(DEPTH);
      up = $urandom_range(DEPTH);
      if (lo > up) begin tr = lo; lo = up; up = tr; end
      tr = lo + $urandom_range(up - lo);
      lvl_lower = CW'(lo); lvl_trig = CW'(tr); lvl_upper = CW'(up);
      for (int k = 0; k < 60; k++) begin
        int c;
        bit pe;
        c = int'(rx_count) + $urandom_range(10) - 5;
        if (c < 0) c = 0;
        if (c > DEPTH) c = DEPTH;
        rx_count = CW'(c);
        if ($urandom_range(15) == 0) sw_rts = ~sw_rts;
        if ($urandom_range(25) == 0) auto_rts_en = ~auto_rts_en;
        pe = auto_rts_en && (c >= tr);
        rts_step("R4/R5/R6 random");
        check("R7 random", rx_thr_irq, pe);
      end
    end

    // R8 CTS blocks while high
    auto_cts_en = 1; cts_n = 1;
    repeat (4) step();
    tx_req = 1;
    count_go(8, gos);
    check("R8 blocked", gos, 0);
    cts_n = 0;
    count_go(5, gos);
    check("R8 granted", gos > 0, 1);
    // R10 busy blocks, pulses never back to back
    tx_busy = 1; step(); step();
    count_go(6, gos);
    check("R10 busy blocks", gos, 0);
    tx_busy = 0;
    count_go(8, gos);
    check("R10 pulsed", gos, 4);
    // R9 CTS ignored when disabled
    tx_req = 0; step(); step();
    auto_cts_en = 0; cts_n = 1;
    repeat (4) step();
    tx_req = 1;
    count_go(4, gos);
    check("R9 ignored", gos, 2);
    tx_req = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule